// File: doc/BRIEF.md
# NMI and External Interrupt Front-End

This block conditions the non-maskable interrupt pin and four external interrupt request pins before they reach a CPU interrupt arbiter. Each raw pin passes through a two-stage synchronizer. The NMI path then detects edges of a selected polarity and holds a request until the CPU acknowledges it. The NMI path respects the CPU block status unless block mode is set. The block-mode bit clears itself in hardware when an NMI is accepted. While the NMI pin is low, a masking option raises a global interrupt mask.

The four external pins have two modes. In the first, they form one active-low level code. In the second, they are four independent active-low level requests. A standby-wake output is raised when a request arrives in standby and the interrupt mask is not set. A 16-bit control register sets every option. Software writes it and reads it back.

Top module: `ift_frontend`

## Requirements
- R1: After reset the control register reads 0x0000 and nmi_req_o, irl_code_o, irl_lines_o, int_mask_o and wake_o are all 0. The synchronizers reset to the idle-high pin level.
- R2: The control register keeps only bits 14 (mask-while-NMI-low), 9 (NMI block mode), 8 (NMI edge select) and 7 (IRL mode). All other bits read 0 and ignore writes.
- R3: With bit 8 = 0, a falling edge on nmi_pin_i sets the NMI pending state, and a rising edge does nothing. With bit 8 = 1, the two edges swap roles. The request appears on nmi_req_o three clock edges after the pin changes.
- R4: Once set, the NMI pending state stays set until nmi_ack_i is sampled high. A new edge in the same cycle as the acknowledge wins over the acknowledge.
- R5: With bit 9 = 0 and bl_i = 1, a pending NMI is held off nmi_req_o. It appears combinationally as soon as bl_i returns to 0.
- R6: With bit 9 = 1, a pending NMI drives nmi_req_o even while bl_i = 1. Sampling nmi_ack_i high clears bit 9, and this takes priority over a register write in the same cycle.
- R7: int_mask_o is 1 only when bit 14 = 1 and the synchronized NMI pin is low. It follows the pin two clock edges later.
- R8: With bit 7 = 0, irl_code_o is the bitwise inverse of the synchronized pins, so pins 1111 give code 0 (no request), and irl_lines_o is 0.
- R9: With bit 7 = 1, irl_lines_o[i] is 1 while pin i is low, and irl_code_o is 0. Pin changes reach the outputs two clock edges later.
- R10: pmode_i encodes 00 normal, 01 sleep, 10 standby, 11 treated as normal. An NMI is presented on nmi_req_o in normal and sleep modes. In standby, nmi_req_o stays 0.
- R11: wake_o is 1 only in standby, only while int_mask_o is 0, and only when an NMI is pending or an external request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 16 | Control register write data |
| cfg_rdata_o | output | 16 | Control register read data |
| nmi_pin_i | input | 1 | Raw NMI pin |
| irl_pin_i | input | 4 | Raw external request pins, active low |
| bl_i | input | 1 | CPU block status bit |
| pmode_i | input | 2 | Power mode |
| nmi_ack_i | input | 1 | NMI accepted by CPU |
| nmi_req_o | output | 1 | NMI request to CPU |
| irl_code_o | output | 4 | Level-encoded external request (0 = none) |
| irl_lines_o | output | 4 | Independent external requests |
| int_mask_o | output | 1 | Global interrupt mask |
| wake_o | output | 1 | Standby wake request |

## Verification
The NMI path is driven with both edge directions under each polarity setting. This shows that the selected edge is detected and the opposite edge is ignored. An edge arriving with bl_i high is tried with block mode off and with block mode on, which tells the held-pending case from the pass-through case and confirms that an acknowledge clears the block bit. The external pins are driven with all-high, mixed and all-low patterns in both modes, which tells the decoded code apart from the independent lines. In standby, the bench puts the NMI pin low with masking on and checks that wake stays off until the pin rises. It then checks that an external request alone also raises wake.

// File: rtl/ift_pkg.sv
package ift_pkg;
  localparam int CFG_W     = 16;
  localparam int BIT_MASK  = 14;
  localparam int BIT_BLK   = 9;
  localparam int BIT_EDGE  = 8;
  localparam int BIT_IRLM  = 7;
  localparam logic [CFG_W-1:0] CFG_WMASK =
    CFG_W'((1 << BIT_MASK) | (1 << BIT_BLK) | (1 << BIT_EDGE) | (1 << BIT_IRLM));

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'b00,
    PM_SLEEP   = 2'b01,
    PM_STANDBY = 2'b10,
    PM_RSVD    = 2'b11
  } pmode_e;

  typedef struct packed {
    logic mask_low;
    logic blk_mode;
    logic edge_rise;
    logic irl_indep;
  } cfg_t;
endpackage

// File: rtl/ift_sync.sv
module ift_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ift_cfg_reg.sv
module ift_cfg_reg
  import ift_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             ack_i,
  output logic [CFG_W-1:0] rdata_o,
  output cfg_t             cfg_o
);
  logic [CFG_W-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= '0;
    end else begin
      if (we_i) reg_q <= wdata_i & CFG_WMASK;
      // acceptance wins over a same-cycle write for the block bit
      if (ack_i) reg_q[BIT_BLK] <= 1'b0;
    end
  end

  assign rdata_o         = reg_q;
  assign cfg_o.mask_low  = reg_q[BIT_MASK];
  assign cfg_o.blk_mode  = reg_q[BIT_BLK];
  assign cfg_o.edge_rise = reg_q[BIT_EDGE];
  assign cfg_o.irl_indep = reg_q[BIT_IRLM];
endmodule

// File: rtl/ift_nmi_ctrl.sv
module ift_nmi_ctrl
  import ift_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   nmi_s_i,
  input  logic   edge_rise_i,
  input  logic   blk_mode_i,
  input  logic   bl_i,
  input  pmode_e pmode_i,
  input  logic   ack_i,
  output logic   pend_o,
  output logic   req_o
);
  logic nmi_d_q, pend_q, edge_hit;

  always_comb begin
    if (edge_rise_i) edge_hit = nmi_s_i & ~nmi_d_q;
    else             edge_hit = ~nmi_s_i & nmi_d_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_d_q <= IDLE_LVL;
      pend_q  <= 1'b0;
    end else begin
      nmi_d_q <= nmi_s_i;
      if (edge_hit)   pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign req_o  = pend_q & (~bl_i | blk_mode_i) & (pmode_i != PM_STANDBY);
endmodule

// File: rtl/ift_irl_decode.sv
module ift_irl_decode #(
  parameter int W = 4
) (
  input  logic [W-1:0] irl_s_i,
  input  logic         indep_i,
  output logic [W-1:0] code_o,
  output logic [W-1:0] lines_o,
  output logic         any_o
);
  logic [W-1:0] act;

  assign act     = ~irl_s_i;
  assign code_o  = indep_i ? '0 : act;
  assign lines_o = indep_i ? act : '0;
  assign any_o   = |act;
endmodule

// File: rtl/ift_frontend.sv
module ift_frontend
  import ift_pkg::*;
#(
  parameter int IRL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             nmi_pin_i,
  input  logic [IRL_W-1:0] irl_pin_i,
  input  logic             bl_i,
  input  logic [1:0]       pmode_i,
  input  logic             nmi_ack_i,
  output logic             nmi_req_o,
  output logic [IRL_W-1:0] irl_code_o,
  output logic [IRL_W-1:0] irl_lines_o,
  output logic             int_mask_o,
  output logic             wake_o
);
  cfg_t   cfg;
  pmode_e pmode;
  logic   nmi_s, nmi_pend, irl_any;
  logic [IRL_W-1:0] irl_s;

  assign pmode = pmode_e'(pmode_i);

  ift_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .ack_i   (nmi_ack_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  ift_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nmi_pin_i),
    .q_o    (nmi_s)
  );

  ift_sync #(.W(IRL_W), .STAGES(SYNC_STAGES), .RST_VAL({IRL_W{1'b1}})) u_sync_irl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irl_pin_i),
    .q_o    (irl_s)
  );

  ift_nmi_ctrl #(.IDLE_LVL(1'b1)) u_nmi (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nmi_s_i     (nmi_s),
    .edge_rise_i (cfg.edge_rise),
    .blk_mode_i  (cfg.blk_mode),
    .bl_i        (bl_i),
    .pmode_i     (pmode),
    .ack_i       (nmi_ack_i),
    .pend_o      (nmi_pend),
    .req_o       (nmi_req_o)
  );

  ift_irl_decode #(.W(IRL_W)) u_irl (
    .irl_s_i (irl_s),
    .indep_i (cfg.irl_indep),
    .code_o  (irl_code_o),
    .lines_o (irl_lines_o),
    .any_o   (irl_any)
  );

  assign int_mask_o = cfg.mask_low & ~nmi_s;
  assign wake_o     = (pmode == PM_STANDBY) & ~int_mask_o & (nmi_pend | irl_any);
endmodule

// File: rtl/ift_frontend_chk.sv
module ift_frontend_chk
  import ift_pkg::*;
#(
  parameter int IRL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_rdata_o,
  input logic             bl_i,
  input logic [1:0]       pmode_i,
  input logic             nmi_ack_i,
  input logic             nmi_req_o,
  input logic [IRL_W-1:0] irl_code_o,
  input logic [IRL_W-1:0] irl_lines_o,
  input logic             int_mask_o,
  input logic             wake_o
);
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o & ~CFG_WMASK) == '0); // R2
  AST_ACK_CLR_BLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_ack_i |=> !cfg_rdata_o[BIT_BLK]); // R6
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o && !nmi_ack_i && !cfg_we_i |=> nmi_req_o || bl_i || (pmode_i == PM_STANDBY)); // R4
  AST_BL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bl_i && !cfg_rdata_o[BIT_BLK] |-> !nmi_req_o); // R5
  AST_MASK_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_mask_o |-> cfg_rdata_o[BIT_MASK]); // R7
  AST_CODE_LINES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|irl_code_o) && (|irl_lines_o))); // R8
  AST_STBY_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmode_i == PM_STANDBY) |-> !nmi_req_o); // R10
  AST_WAKE_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (pmode_i == PM_STANDBY) && !int_mask_o); // R11
endmodule

bind ift_frontend ift_frontend_chk #(.IRL_W(IRL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_rdata_o (cfg_rdata_o),
  .bl_i        (bl_i),
  .pmode_i     (pmode_i),
  .nmi_ack_i   (nmi_ack_i),
  .nmi_req_o   (nmi_req_o),
  .irl_code_o  (irl_code_o),
  .irl_lines_o (irl_lines_o),
  .int_mask_o  (int_mask_o),
  .wake_o      (wake_o)
);

// File: tb/tb_ift_frontend.sv
`timescale 1ns/1ps
module tb_ift_frontend;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic        nmi_pin_i = 1'b1;
  logic [3:0]  irl_pin_i = 4'hF;
  logic        bl_i = 1'b0;
  logic [1:0]  pmode_i = 2'b00;
  logic        nmi_ack_i = 1'b0;
  logic        nmi_req_o;
  logic [3:0]  irl_code_o, irl_lines_o;
  logic        int_mask_o, wake_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  ift_frontend dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .nmi_pin_i(nmi_pin_i), .irl_pin_i(irl_pin_i),
    .bl_i(bl_i), .pmode_i(pmode_i), .nmi_ack_i(nmi_ack_i), .nmi_req_o(nmi_req_o),
    .irl_code_o(irl_code_o), .irl_lines_o(irl_lines_o), .int_mask_o(int_mask_o),
    .wake_o(wake_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [15:0] v);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    step(1);
    cfg_we_i = 1'b0;
  endtask

  task automatic ack();
    nmi_ack_i = 1'b1;
    step(1);
    nmi_ack_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cfg", cfg_rdata_o, 16'h0000);
    chk("R1 req", {15'd0, nmi_req_o}, 16'd0);
    chk("R1 code", {12'd0, irl_code_o}, 16'd0);
    chk("R1 lines", {12'd0, irl_lines_o}, 16'd0);
    chk("R1 mask", {15'd0, int_mask_o}, 16'd0);
    chk("R1 wake", {15'd0, wake_o}, 16'd0);
  endtask

  task automatic t_reg();
    wr_cfg(16'hFFFF);
    chk("R2 all ones", cfg_rdata_o, 16'h4380);
    wr_cfg(16'h3C7F);
    chk("R2 reserved", cfg_rdata_o, 16'h0000);
    wr_cfg(16'h0000);
    chk("R2 clear", cfg_rdata_o, 16'h0000);
  endtask

  task automatic t_edge();
    nmi_pin_i = 1'b0; step(2);
    chk("R3 latency", {15'd0, nmi_req_o}, 16'd0);
    step(1);
    chk("R3 falling", {15'd0, nmi_req_o}, 16'd1);
    step(5);
    chk("R4 held", {15'd0, nmi_req_o}, 16'd1);
    ack();
    chk("R4 ack clears", {15'd0, nmi_req_o}, 16'd0);
    nmi_pin_i = 1'b1; step(3);
    chk("R3 rising ignored", {15'd0, nmi_req_o}, 16'd0);
    wr_cfg(16'h0100);
    nmi_pin_i = 1'b0; step(3);
    chk("R3 falling ignored", {15'd0, nmi_req_o}, 16'd0);
    nmi_pin_i = 1'b1; step(3);
    chk("R3 rising", {15'd0, nmi_req_o}, 16'd1);
    ack();
    wr_cfg(16'h0000);
    chk("R4 cleared", {15'd0, nmi_req_o}, 16'd0);
  endtask

  task automatic t_bl();
    bl_i = 1'b1;
    nmi_pin_i = 1'b0; step(3);
    chk("R5 held by BL", {15'd0, nmi_req_o}, 16'd0);
    step(4);
    chk("R5 still held", {15'd0, nmi_req_o}, 16'd0);
    bl_i = 1'b0; #1;
    chk("R5 released", {15'd0, nmi_req_o}, 16'd1);
    ack();
    nmi_pin_i = 1'b1; step(3);
  endtask

  task automatic t_blk();
    wr_cfg(16'h0200);
    bl_i = 1'b1;
    nmi_pin_i = 1'b0; step(3);
    chk("R6 pass while BL", {15'd0, nmi_req_o}, 16'd1);
    chk("R6 blk set", {15'd0, cfg_rdata_o[9]}, 16'd1);
    ack();
    chk("R6 blk self-clear", {15'd0, cfg_rdata_o[9]}, 16'd0);
    chk("R6 req cleared", {15'd0, nmi_req_o}, 16'd0);
    nmi_pin_i = 1'b1; step(3);
    nmi_pin_i = 1'b0; step(3);
    chk("R6 held after clear", {15'd0, nmi_req_o}, 16'd0);
    bl_i = 1'b0; #1;
    chk("R6 released", {15'd0, nmi_req_o}, 16'd1);
    // write setting block bit together with ack: ack wins
    cfg_we_i = 1'b1; cfg_wdata_i = 16'h0200; nmi_ack_i = 1'b1;
    step(1);
    cfg_we_i = 1'b0; nmi_ack_i = 1'b0;
    chk("R6 ack over write", {15'd0, cfg_rdata_o[9]}, 16'd0);
    nmi_pin_i = 1'b1; step(3);
    wr_cfg(16'h0000);
  endtask

  task automatic t_mask();
    wr_cfg(16'h4000);
    nmi_pin_i = 1'b0; step(2);
    chk("R7 mask on low", {15'd0, int_mask_o}, 16'd1);
    nmi_pin_i = 1'b1; step(2);
    chk("R7 mask off high", {15'd0, int_mask_o}, 16'd0);
    ack();
    wr_cfg(16'h0000);
    nmi_pin_i = 1'b0; step(2);
    chk("R7 mask disabled", {15'd0, int_mask_o}, 16'd0);
    step(1); ack();
    nmi_pin_i = 1'b1; step(3);
  endtask

  task automatic t_irl();
    irl_pin_i = 4'b1111; step(2);
    chk("R8 idle code", {12'd0, irl_code_o}, 16'd0);
    irl_pin_i = 4'b0101; step(2);
    chk("R8 code mixed", {12'd0, irl_code_o}, 16'h000A);
    chk("R8 lines zero", {12'd0, irl_lines_o}, 16'd0);
    irl_pin_i = 4'b0000; step(2);
    chk("R8 code max", {12'd0, irl_code_o}, 16'h000F);
    wr_cfg(16'h0080);
    irl_pin_i = 4'b0110; step(2);
    chk("R9 lines", {12'd0, irl_lines_o}, 16'h0009);
    chk("R9 code zero", {12'd0, irl_code_o}, 16'd0);
    irl_pin_i = 4'b1111; step(2);
    chk("R9 lines idle", {12'd0, irl_lines_o}, 16'd0);
    wr_cfg(16'h0000);
  endtask

  task automatic t_power();
    pmode_i = 2'b01;
    nmi_pin_i = 1'b0; step(3);
    chk("R10 sleep req", {15'd0, nmi_req_o}, 16'd1);
    pmode_i = 2'b10; #1;
    chk("R10 standby no req", {15'd0, nmi_req_o}, 16'd0);
    chk("R11 wake on nmi", {15'd0, wake_o}, 16'd1);
    ack();
    chk("R11 wake cleared", {15'd0, wake_o}, 16'd0);
    nmi_pin_i = 1'b1; step(3);
    wr_cfg(16'h4000);
    nmi_pin_i = 1'b0; step(3);
    chk("R11 masked no wake", {15'd0, wake_o}, 16'd0);
    nmi_pin_i = 1'b1; step(2);
    chk("R11 wake after rise", {15'd0, wake_o}, 16'd1);
    ack();
    wr_cfg(16'h0000);
    irl_pin_i = 4'b1110; step(2);
    chk("R11 wake on irl", {15'd0, wake_o}, 16'd1);
    irl_pin_i = 4'b1111; step(2);
    pmode_i = 2'b00; #1;
    chk("R11 no wake normal", {15'd0, wake_o}, 16'd0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(3);
    t_reset();
    t_reg();
    t_edge();
    t_bl();
    t_blk();
    t_mask();
    t_irl();
    t_power();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule